// File: doc/BRIEF.md
# Dual-Register Shift Unit

This block pairs a parallel input storage register with a shift register of the same width. Both sit on one shared bidirectional data port. The port is presented as three separate signals: a data-in bus, a data-out bus and an output-enable flag that drives the pad. The storage register takes the port value on a rising edge of its own storage clock. The shift register can do one of four things: clear, hold, take the stored word through a level-sensitive load, or shift toward the high end from one of two serial sources. Its last stage drives a serial output that is always active.

The shift clock and the storage clock are slow control inputs. The block samples them on one free-running system clock and finds their rising edges there. Every register change therefore lands on the system clock edge that follows the cycle in which the triggering condition is present. The load operates on the level of its input, once per system cycle. It acts only while the shift clock is low. When the storage clock rises in the same cycle as an active load, the captured port value passes straight into the shift register. Driving the shift-register clear and the load together is not a valid use. In that case the model lets the clear win.

Top module: `dual_shift_unit`

## Requirements
- R1: While `clr_n_i` is 0 in a system cycle, the shift register and `ser_o` are 0 after the next system clock edge, whatever the other controls do.
- R2: While `shen_n_i` is 1 and `clr_n_i` is 1, the shift register keeps its value. Shift-clock edges and load are ignored.
- R3: With `shen_n_i` 0, `clr_n_i` 1 and `ld_n_i` 0, the shift register becomes the storage word if `shclk_i` is 0 in that cycle. It keeps its value if `shclk_i` is 1.
- R4: With `shen_n_i` 0, `clr_n_i` 1 and `ld_n_i` 1, a rising edge of `shclk_i` shifts the register by one place. Bit 0 takes the serial input and bit n takes bit n-1. A rising edge is 1 in this cycle after 0 in the previous cycle, and after reset the previous value counts as 1. `ser_o` is always bit WIDTH-1 of the register.
- R5: The serial input is `ser0_i` when `sel_i` is 0 and `ser1_i` when `sel_i` is 1.
- R6: A rising edge of `stclk_i` (same edge rule as R4) copies `pin_i` into the storage register. At any other time the storage register keeps its value, and this is seen through a later load.
- R7: When the conditions of R3 hold with `shclk_i` 0 and `stclk_i` rises in the same cycle, the shift register takes the `pin_i` value of that cycle.
- R8: `pin_oe_o` is 1 exactly when `oe_n_i` is 0, with no clock delay. `pin_o` always shows the shift register. `oe_n_i` has no effect on either register.
- R9: While `rst_n` is 0, both registers are 0, so `pin_o` and `ser_o` read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low system reset |
| shclk_i | input | 1 | Shift clock level, sampled |
| shen_n_i | input | 1 | Active-low shift enable |
| ld_n_i | input | 1 | Active-low level load of the stored word |
| clr_n_i | input | 1 | Active-low shift-register clear |
| sel_i | input | 1 | Serial source select |
| ser0_i | input | 1 | Serial source 0 |
| ser1_i | input | 1 | Serial source 1 |
| stclk_i | input | 1 | Storage clock level, sampled |
| oe_n_i | input | 1 | Active-low port output enable |
| pin_i | input | WIDTH | Port value seen at the pads |
| pin_o | output | WIDTH | Shift-register value for the pads |
| pin_oe_o | output | 1 | Pad drive enable |
| ser_o | output | 1 | Serial output, last stage |

## Verification
The assertions assume that the clear and the load are never active in the same cycle. They also assume that the clock inputs change only in step with the system clock, so that an edge is a one-cycle 0-to-1 step of the sampled level. The bench changes every input only on the falling system edge. In both its directed sweeps and its random mix it holds the load inactive whenever the clear is active. This keeps the invalid combination out of every checked cycle. Storage contents are observed only through a later load onto `pin_o`.

// File: rtl/dsu_pkg.sv
`timescale 1ns/1ps
package dsu_pkg;

   typedef enum logic [1:0] {
      SR_HOLD  = 2'd0,
      SR_CLEAR = 2'd1,
      SR_LOAD  = 2'd2,
      SR_SHIFT = 2'd3
   } sr_act_e;

   // Priority: clear, then enable, then load level, then shift edge.
   function automatic sr_act_e pick_act(input logic clr_n,
                                        input logic en_n,
                                        input logic ld_n,
                                        input logic shclk_lvl,
                                        input logic shclk_rise);
      sr_act_e a;
      if (!clr_n)          a = SR_CLEAR;
      else if (en_n)       a = SR_HOLD;
      else if (!ld_n)      a = shclk_lvl ? SR_HOLD : SR_LOAD;
      else if (shclk_rise) a = SR_SHIFT;
      else                 a = SR_HOLD;
      return a;
   endfunction

endpackage

// File: rtl/dsu_edge.sv
`timescale 1ns/1ps
module dsu_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] prev_q;

   for (genvar k = 0; k < N; k++) begin : g_det
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[k] <= 1'b1;
         else        prev_q[k] <= lvl_i[k];
      end
      assign rise_o[k] = lvl_i[k] & ~prev_q[k];
   end
endmodule

// File: rtl/dsu_store.sv
`timescale 1ns/1ps
module dsu_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_i,
   input  logic [WIDTH-1:0] port_i,
   output logic [WIDTH-1:0] word_q,
   output logic [WIDTH-1:0] word_nxt_o
);
   assign word_nxt_o = cap_i ? port_i : word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_nxt_o;
   end
endmodule

// File: rtl/dsu_shift.sv
`timescale 1ns/1ps
module dsu_shift
   import dsu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sr_act_e          act_i,
   input  logic [WIDTH-1:0] load_i,
   input  logic             ser_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] nxt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic shin;
      if (i == 0) begin : g_head
         assign shin = ser_i;
      end else begin : g_body
         assign shin = q_o[i-1];
      end
      always_comb begin
         unique case (act_i)
            SR_CLEAR: nxt[i] = 1'b0;
            SR_LOAD:  nxt[i] = load_i[i];
            SR_SHIFT: nxt[i] = shin;
            default:  nxt[i] = q_o[i];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/dual_shift_unit.sv
`timescale 1ns/1ps
module dual_shift_unit
   import dsu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shclk_i,
   input  logic             shen_n_i,
   input  logic             ld_n_i,
   input  logic             clr_n_i,
   input  logic             sel_i,
   input  logic             ser0_i,
   input  logic             ser1_i,
   input  logic             stclk_i,
   input  logic             oe_n_i,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] pin_o,
   output logic             pin_oe_o,
   output logic             ser_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("dual_shift_unit: WIDTH must be at least 2");
   end

   logic [1:0]       rise;
   logic             sh_rise;
   logic             st_rise;
   logic [WIDTH-1:0] store_q;
   logic [WIDTH-1:0] store_nxt;
   sr_act_e          act;
   logic             ser_bit;
   logic [WIDTH-1:0] sreg_q;

   dsu_edge #(.N(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({stclk_i, shclk_i}),
      .rise_o (rise)
   );
   assign sh_rise = rise[0];
   assign st_rise = rise[1];

   dsu_store #(.WIDTH(WIDTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_i      (st_rise),
      .port_i     (pin_i),
      .word_q     (store_q),
      .word_nxt_o (store_nxt)
   );

   assign act     = pick_act(clr_n_i, shen_n_i, ld_n_i, shclk_i, sh_rise);
   assign ser_bit = sel_i ? ser1_i : ser0_i;

   dsu_shift #(.WIDTH(WIDTH)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act),
      .load_i (store_nxt),
      .ser_i  (ser_bit),
      .q_o    (sreg_q)
   );

   assign pin_o    = sreg_q;
   assign ser_o    = sreg_q[MSB];
   assign pin_oe_o = ~oe_n_i;
endmodule

// File: rtl/dual_shift_unit_chk.sv
`timescale 1ns/1ps
module dual_shift_unit_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shen_n_i,
   input logic             ld_n_i,
   input logic             clr_n_i,
   input logic             shclk_i,
   input logic             sel_i,
   input logic             ser0_i,
   input logic             ser1_i,
   input logic [WIDTH-1:0] pin_i,
   input logic [WIDTH-1:0] pin_o,
   input logic             ser_o,
   input logic             sh_rise,
   input logic             st_rise,
   input logic [WIDTH-1:0] store_q
);
   assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_i |=> (pin_o == '0) && !ser_o);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && shen_n_i) |=> $stable(pin_o));

   // R3 and R7: after a load the register equals the storage word as updated.
   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && !shen_n_i && !ld_n_i && !shclk_i) |=> (pin_o == store_q));

   assert_noload_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && !shen_n_i && !ld_n_i && shclk_i) |=> $stable(pin_o));

   // R4 and R5
   assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && !shen_n_i && ld_n_i && sh_rise) |=>
         (pin_o == {$past(pin_o[WIDTH-2:0]), $past(sel_i ? ser1_i : ser0_i)}));

   assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_rise |=> (store_q == $past(pin_i)));

   assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !st_rise |=> $stable(store_q));

   assert_serial_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && !shen_n_i && ld_n_i && sh_rise) |=> (ser_o == $past(pin_o[WIDTH-2])));
endmodule

bind dual_shift_unit dual_shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .shen_n_i (shen_n_i),
   .ld_n_i   (ld_n_i),
   .clr_n_i  (clr_n_i),
   .shclk_i  (shclk_i),
   .sel_i    (sel_i),
   .ser0_i   (ser0_i),
   .ser1_i   (ser1_i),
   .pin_i    (pin_i),
   .pin_o    (pin_o),
   .ser_o    (ser_o),
   .sh_rise  (sh_rise),
   .st_rise  (st_rise),
   .store_q  (store_q)
);

// File: tb/dual_shift_unit_bench.sv
`timescale 1ns/1ps
module dual_shift_unit_bench;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shclk_i = 1'b0, shen_n_i = 1'b0, ld_n_i = 1'b1, clr_n_i = 1'b1;
   logic sel_i = 1'b0, ser0_i = 1'b0, ser1_i = 1'b0, stclk_i = 1'b0, oe_n_i = 1'b1;
   logic [W-1:0] pin_i = '0;
   logic [W-1:0] pin_o;
   logic pin_oe_o, ser_o;

   // next-cycle stimulus set by the sequence, applied by step()
   logic n_shc = 0, n_en_n = 0, n_ld_n = 1, n_clr_n = 1, n_sel = 0;
   logic n_s0 = 0, n_s1 = 0, n_stc = 0, n_oe_n = 1;
   logic [W-1:0] n_din = '0;

   // bench reference state
   logic [W-1:0] m_store = '0, m_sreg = '0;
   logic m_shprev = 1'b1, m_stprev = 1'b1;

   int checks = 0, failures = 0;
   bit done = 0;

   dual_shift_unit #(.WIDTH(W)) u_dual_shift_unit (
      .clk(clk), .rst_n(rst_n), .shclk_i(shclk_i), .shen_n_i(shen_n_i),
      .ld_n_i(ld_n_i), .clr_n_i(clr_n_i), .sel_i(sel_i), .ser0_i(ser0_i),
      .ser1_i(ser1_i), .stclk_i(stclk_i), .oe_n_i(oe_n_i), .pin_i(pin_i),
      .pin_o(pin_o), .pin_oe_o(pin_oe_o), .ser_o(ser_o)
   );

   always #5 clk = ~clk;

   task automatic check_out(input string req);
      checks++;
      if (pin_o !== m_sreg || ser_o !== m_sreg[W-1] || pin_oe_o !== ~n_oe_n) begin
         failures++;
         $display("FAIL %s pin_o=%h ser_o=%b oe=%b expected pin_o=%h ser_o=%b oe=%b",
                  req, pin_o, ser_o, pin_oe_o, m_sreg, m_sreg[W-1], ~n_oe_n);
      end
   endtask

   task automatic step(input string req);
      logic shr, str;
      logic [W-1:0] nst, nsr;
      @(negedge clk);
      shclk_i = n_shc; shen_n_i = n_en_n; ld_n_i = n_ld_n; clr_n_i = n_clr_n;
      sel_i = n_sel; ser0_i = n_s0; ser1_i = n_s1; stclk_i = n_stc;
      oe_n_i = n_oe_n; pin_i = n_din;
      shr = n_shc & ~m_shprev;
      str = n_stc & ~m_stprev;
      nst = str ? n_din : m_store;
      nsr = m_sreg;
      if (!n_clr_n) nsr = '0;
      else if (!n_en_n) begin
         if (!n_ld_n) begin
            if (!n_shc) nsr = nst;
         end else if (shr) begin
            nsr = W'((m_sreg * 2) + (n_sel ? n_s1 : n_s0));
         end
      end
      @(posedge clk);
      #1;
      m_store = nst; m_sreg = nsr; m_shprev = n_shc; m_stprev = n_stc;
      check_out(req);
   endtask

   task automatic idle_ctrl();
      n_shc = 0; n_en_n = 0; n_ld_n = 1; n_clr_n = 1; n_stc = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : seq
      repeat (3) @(posedge clk);
      #1;
      check_out("R9 reset state");
      @(negedge clk);
      rst_n = 1'b1;

      // R6, R3, R8: capture every value, then load it onto the port
      for (int v = 0; v < 256; v++) begin
         idle_ctrl(); n_oe_n = v[0]; n_din = W'(v);
         step("R8 idle");
         n_stc = 1;
         step("R6 capture");
         n_stc = 0; n_din = ~W'(v); n_ld_n = 0;
         step("R3 load stored word");
      end

      // R6: no capture without an edge, stclk held high
      idle_ctrl(); n_stc = 1; n_din = 8'h3C; step("R6 capture");
      n_din = 8'hC3; repeat (3) step("R6 held high no capture");
      n_stc = 0; n_ld_n = 0; step("R6 stored word kept");

      // R4, R5: all source combinations
      for (int c = 0; c < 4; c++) begin
         idle_ctrl(); n_sel = c[1]; n_s0 = c[0]; n_s1 = ~c[0];
         for (int k = 0; k < W + 1; k++) begin
            n_shc = 1; step("R5 shift rise");
            n_shc = 0; step("R4 shift no edge");
            n_s0 = ~n_s0;
         end
      end

      // R2: enable high blocks shift and load
      idle_ctrl(); n_stc = 1; n_din = 8'h5A; step("R6 capture");
      n_stc = 0; n_ld_n = 0; step("R3 load");
      n_ld_n = 1; n_en_n = 1; n_sel = 0; n_s0 = 1;
      for (int k = 0; k < 4; k++) begin
         n_shc = 1; step("R2 hold on edge");
         n_shc = 0; n_ld_n = 0; n_stc = 1; n_din = 8'hFF; step("R2 hold on load");
         n_ld_n = 1; n_stc = 0;
      end

      // R3: load blocked while shift clock high
      idle_ctrl(); n_stc = 1; n_din = 8'h81; step("R6 capture");
      n_stc = 0; n_shc = 1; n_ld_n = 0; step("R3 no load while high");
      step("R3 no load while high");
      n_shc = 0; step("R3 load after fall");

      // R7: flow-through load
      for (int v = 0; v < 16; v++) begin
         idle_ctrl(); step("R7 idle");
         n_ld_n = 0; n_stc = 1; n_din = W'(v * 17 + 3); step("R7 flow-through");
      end

      // R1: clear overrides shift and enable
      idle_ctrl(); n_stc = 1; n_din = 8'hF7; step("R6 capture");
      n_stc = 0; n_ld_n = 0; step("R3 load");
      n_ld_n = 1; n_clr_n = 0; n_shc = 1; n_s0 = 1; step("R1 clear over shift");
      n_shc = 0; n_ld_n = 0; n_clr_n = 1; step("R3 reload");
      n_ld_n = 1; n_en_n = 1; n_clr_n = 0; step("R1 clear with enable high");

      // R8: oe has no effect on registers; random mix
      for (int k = 0; k < 3000; k++) begin
         logic [15:0] r;
         r = 16'($urandom);
         n_shc = r[0]; n_en_n = (r[3:1] == 3'd0); n_clr_n = (r[6:4] != 3'd0);
         n_ld_n = n_clr_n ? r[7] : 1'b1; n_sel = r[8]; n_s0 = r[9]; n_s1 = r[10];
         n_stc = r[11]; n_oe_n = r[12]; n_din = W'($urandom);
         step("R8 mixed");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule